// File: doc/BRIEF.md
# Three-C Cache Miss Classifier

This block watches a stream of block addresses, one per cycle in which the request strobe is high. It keeps the tags of a small direct-mapped cache, which is the cache being studied. Beside that cache it keeps two more structures. The first is a fully-associative tag store with the same number of entries, replaced in least-recently-used order. The second is a bit vector that marks every block address seen since reset. Using these three, it decides whether each reference is a hit or which kind of miss it is.

A miss on an address never seen before is compulsory. For any other miss the block asks whether the fully-associative store would have held the block. If it would, the loss comes from the mapping and the miss is a conflict. If it would not, the miss is a capacity miss. No data is stored.

The answer for each reference comes out one cycle later on a result strobe with a two-bit class code. Saturating counters keep the number of references and the number of each class, so the miss rate is (compulsory + capacity + conflict) / references.

Top module: `mcls_classifier`

## Requirements
- R1: `res_valid` is high in the cycle after each cycle with `req_valid` high, and is low otherwise. In a cycle with no request, no counter changes.
- R2: `res_class` holds the class of the reference from the previous cycle, coded 2'b00 hit, 2'b01 compulsory, 2'b10 capacity, 2'b11 conflict.
- R3: A reference to an address not referenced since reset is reported as compulsory, whatever either tag store holds.
- R4: `cnt_comp` equals the number of distinct addresses referenced since reset, and never exceeds 2**ADDR_W.
- R5: The direct-mapped store uses the low log2(NUM_BLOCKS) address bits as the set index and the remaining bits as the tag. A reference hits when its set is valid and holds its tag.
- R6: A miss on an address already seen is reported as capacity if the shadow store also misses, and as conflict if the shadow store hits.
- R7: The shadow store has NUM_BLOCKS fully-associative entries. Each reference, hit or miss, makes its block the most recent. A miss replaces the least recently used entry.
- R8: All three structures are updated on every reference, and each reference is classified from the state before its own update. A repeat of the same address in the next cycle is therefore a hit.
- R9: With two blocks and three addresses A, B and C in one set, the order C C B C B C A C B yields compulsory, hit, compulsory, conflict, conflict, conflict, compulsory, conflict, capacity.
- R10: `cnt_refs` increments by one per reference. While no counter is saturated, it equals the sum of the four class counters.
- R11: Each counter stops at its all-ones value and holds there.
- R12: Reset clears every counter, `res_valid`, all valid bits and all seen bits, so the first reference after reset is compulsory again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A reference is present this cycle |
| req_addr | input | ADDR_W | Block address of the reference |
| res_valid | output | 1 | Result strobe, one cycle after the request |
| res_class | output | 2 | Class code of that reference |
| cnt_refs | output | CNT_W | Total references |
| cnt_hit | output | CNT_W | Hits |
| cnt_comp | output | CNT_W | Compulsory misses |
| cnt_cap | output | CNT_W | Capacity misses |
| cnt_conf | output | CNT_W | Conflict misses |

## Verification
The properties assume that `req_addr` is a known value whenever `req_valid` is high, and that `req_valid` is never unknown once reset is released. The bench drives both signals only at the falling edge and always to defined values. The sum-of-counters property assumes that the reference counter is the first to saturate. That holds because it is never smaller than any class counter. A second, narrow-counter instance reaches saturation early so that the limit is exercised.

// File: rtl/mcls_pkg.sv
`timescale 1ns/1ps
package mcls_pkg;
  typedef enum logic [1:0] {
    CLS_HIT  = 2'b00,
    CLS_COMP = 2'b01,
    CLS_CAP  = 2'b10,
    CLS_CONF = 2'b11
  } miss_cls_e;

  localparam int unsigned NUM_CLS = 4;
endpackage

// File: rtl/mcls_dm_tags.sv
`timescale 1ns/1ps
// Direct-mapped tag array of the observed cache: index = low address bits.
module mcls_dm_tags #(
  parameter int unsigned ADDR_W     = 6,
  parameter int unsigned NUM_BLOCKS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_en,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  localparam int unsigned IDX_W = $clog2(NUM_BLOCKS);
  localparam int unsigned TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0]      idx;
  logic [TAG_W-1:0]      tag;
  logic [NUM_BLOCKS-1:0] line_v_q;
  logic [TAG_W-1:0]      line_t_q [NUM_BLOCKS];
  logic [NUM_BLOCKS-1:0] line_we;

  assign idx = addr[IDX_W-1:0];
  assign tag = addr[ADDR_W-1:IDX_W];

  always_comb begin
    hit = line_v_q[idx] && (line_t_q[idx] == tag);
  end

  for (genvar i = 0; i < NUM_BLOCKS; i++) begin : g_line
    assign line_we[i] = upd_en && (idx == IDX_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        line_v_q[i] <= 1'b0;
        line_t_q[i] <= '0;
      end else if (line_we[i]) begin
        line_v_q[i] <= 1'b1;
        line_t_q[i] <= tag;
      end
    end
  end
endmodule

// File: rtl/mcls_fa_lru.sv
`timescale 1ns/1ps
// Shadow fully-associative tag store with rank-based LRU (rank 0 = most recent).
module mcls_fa_lru #(
  parameter int unsigned ADDR_W     = 6,
  parameter int unsigned NUM_BLOCKS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_en,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  localparam int unsigned RK_W = $clog2(NUM_BLOCKS);
  localparam logic [RK_W-1:0] RK_LAST = RK_W'(NUM_BLOCKS - 1);

  logic [NUM_BLOCKS-1:0] ent_v_q;
  logic [ADDR_W-1:0]     ent_a_q [NUM_BLOCKS];
  logic [RK_W-1:0]       ent_r_q [NUM_BLOCKS];
  logic [RK_W-1:0]       ent_r_d [NUM_BLOCKS];
  logic [NUM_BLOCKS-1:0] match;
  logic [NUM_BLOCKS-1:0] oldest;
  logic [NUM_BLOCKS-1:0] sel;
  logic [RK_W-1:0]       sel_rank;

  for (genvar i = 0; i < NUM_BLOCKS; i++) begin : g_cmp
    assign match[i]  = ent_v_q[i] && (ent_a_q[i] == addr);
    assign oldest[i] = (ent_r_q[i] == RK_LAST);
  end

  assign hit = |match;
  // Untouched (invalid) entries always sit at the tail of the ranking,
  // so the oldest rank names an invalid entry while one exists.
  assign sel = hit ? match : oldest;

  always_comb begin
    sel_rank = '0;
    for (int i = 0; i < NUM_BLOCKS; i++) begin
      if (sel[i]) sel_rank = sel_rank | ent_r_q[i];
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_BLOCKS; i++) begin
      if (sel[i])                        ent_r_d[i] = '0;
      else if (ent_r_q[i] < sel_rank)    ent_r_d[i] = ent_r_q[i] + RK_W'(1);
      else                               ent_r_d[i] = ent_r_q[i];
    end
  end

  for (genvar i = 0; i < NUM_BLOCKS; i++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_v_q[i] <= 1'b0;
        ent_a_q[i] <= '0;
        ent_r_q[i] <= RK_W'(i);
      end else if (upd_en) begin
        ent_r_q[i] <= ent_r_d[i];
        if (sel[i]) begin
          ent_v_q[i] <= 1'b1;
          ent_a_q[i] <= addr;
        end
      end
    end
  end
endmodule

// File: rtl/mcls_seen.sv
`timescale 1ns/1ps
// One bit per block address; set on first reference, cleared only by reset.
module mcls_seen #(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_en,
  input  logic [ADDR_W-1:0] addr,
  output logic              was_seen
);
  localparam int unsigned SPACE = 1 << ADDR_W;

  logic [SPACE-1:0] seen_q;
  logic [SPACE-1:0] seen_d;

  assign was_seen = seen_q[addr];

  always_comb begin
    seen_d = seen_q;
    if (upd_en) seen_d[addr] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= '0;
    else        seen_q <= seen_d;
  end
endmodule

// File: rtl/mcls_sat_cnt.sv
`timescale 1ns/1ps
module mcls_sat_cnt #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] value
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             at_max;

  assign at_max = &cnt_q;
  assign value  = cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (inc && !at_max) cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/mcls_classifier.sv
`timescale 1ns/1ps
module mcls_classifier #(
  parameter int unsigned ADDR_W     = 6,
  parameter int unsigned NUM_BLOCKS = 4,
  parameter int unsigned CNT_W      = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              res_valid,
  output logic [1:0]        res_class,
  output logic [CNT_W-1:0]  cnt_refs,
  output logic [CNT_W-1:0]  cnt_hit,
  output logic [CNT_W-1:0]  cnt_comp,
  output logic [CNT_W-1:0]  cnt_cap,
  output logic [CNT_W-1:0]  cnt_conf
);
  import mcls_pkg::*;

  logic      dm_hit;
  logic      fa_hit;
  logic      seen;
  miss_cls_e cls_d;
  logic      res_valid_q;
  miss_cls_e res_class_q;
  logic [NUM_CLS-1:0] cls_inc;
  logic [CNT_W-1:0]   cls_cnt [NUM_CLS];

  mcls_dm_tags #(.ADDR_W(ADDR_W), .NUM_BLOCKS(NUM_BLOCKS)) u_dm (
    .clk(clk), .rst_n(rst_n), .upd_en(req_valid), .addr(req_addr), .hit(dm_hit)
  );

  mcls_fa_lru #(.ADDR_W(ADDR_W), .NUM_BLOCKS(NUM_BLOCKS)) u_fa (
    .clk(clk), .rst_n(rst_n), .upd_en(req_valid), .addr(req_addr), .hit(fa_hit)
  );

  mcls_seen #(.ADDR_W(ADDR_W)) u_seen (
    .clk(clk), .rst_n(rst_n), .upd_en(req_valid), .addr(req_addr), .was_seen(seen)
  );

  // Classification from pre-update state.
  always_comb begin
    if (dm_hit)      cls_d = CLS_HIT;
    else if (!seen)  cls_d = CLS_COMP;
    else if (fa_hit) cls_d = CLS_CONF;
    else             cls_d = CLS_CAP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid_q <= 1'b0;
      res_class_q <= CLS_HIT;
    end else begin
      res_valid_q <= req_valid;
      if (req_valid) res_class_q <= cls_d;
    end
  end

  assign res_valid = res_valid_q;
  assign res_class = res_class_q;

  mcls_sat_cnt #(.CNT_W(CNT_W)) u_cnt_refs (
    .clk(clk), .rst_n(rst_n), .inc(req_valid), .value(cnt_refs)
  );

  for (genvar k = 0; k < NUM_CLS; k++) begin : g_cls_cnt
    assign cls_inc[k] = req_valid && (cls_d == miss_cls_e'(k));
    mcls_sat_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .inc(cls_inc[k]), .value(cls_cnt[k])
    );
  end

  assign cnt_hit  = cls_cnt[CLS_HIT];
  assign cnt_comp = cls_cnt[CLS_COMP];
  assign cnt_cap  = cls_cnt[CLS_CAP];
  assign cnt_conf = cls_cnt[CLS_CONF];
endmodule

// File: rtl/mcls_classifier_chk.sv
`timescale 1ns/1ps
module mcls_classifier_chk #(
  parameter int unsigned ADDR_W     = 6,
  parameter int unsigned NUM_BLOCKS = 4,
  parameter int unsigned CNT_W      = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic              res_valid,
  input logic [1:0]        res_class,
  input logic [CNT_W-1:0]  cnt_refs,
  input logic [CNT_W-1:0]  cnt_hit,
  input logic [CNT_W-1:0]  cnt_comp,
  input logic [CNT_W-1:0]  cnt_cap,
  input logic [CNT_W-1:0]  cnt_conf
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  p_res_follows_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> res_valid);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!res_valid && $stable(cnt_refs) && $stable(cnt_comp)));

  p_class_known_r2: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !$isunknown(res_class));

  p_comp_tally_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_class == 2'b01) |-> (cnt_comp == CMAX || cnt_comp == $past(cnt_comp) + CNT_W'(1)));

  p_comp_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    longint'(cnt_comp) <= (longint'(1) << ADDR_W));

  p_refs_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && cnt_refs != CMAX) |=> (cnt_refs == $past(cnt_refs) + CNT_W'(1)));

  p_sum_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_refs != CMAX) |->
      ({2'b00, cnt_hit} + {2'b00, cnt_comp} + {2'b00, cnt_cap} + {2'b00, cnt_conf}) == {2'b00, cnt_refs});

  p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_refs == CMAX) |=> (cnt_refs == CMAX));
endmodule

bind mcls_classifier mcls_classifier_chk #(
  .ADDR_W(ADDR_W), .NUM_BLOCKS(NUM_BLOCKS), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
  .res_valid(res_valid), .res_class(res_class), .cnt_refs(cnt_refs),
  .cnt_hit(cnt_hit), .cnt_comp(cnt_comp), .cnt_cap(cnt_cap), .cnt_conf(cnt_conf)
);

// File: tb/tb_mcls_classifier.sv
`timescale 1ns/1ps
module tb_mcls_classifier;
  localparam int AW = 5;
  localparam int NB = 2;
  localparam int CW = 32;
  localparam int SW = 4;

  logic clk;
  logic rst_n;
  logic req_valid;
  logic [AW-1:0] req_addr;
  logic res_valid;
  logic [1:0] res_class;
  logic [CW-1:0] cnt_refs, cnt_hit, cnt_comp, cnt_cap, cnt_conf;
  logic s_valid;
  logic [1:0] s_class;
  logic [SW-1:0] s_refs, s_hit, s_comp, s_cap, s_conf;

  mcls_classifier #(.ADDR_W(AW), .NUM_BLOCKS(NB), .CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .res_valid(res_valid), .res_class(res_class), .cnt_refs(cnt_refs),
    .cnt_hit(cnt_hit), .cnt_comp(cnt_comp), .cnt_cap(cnt_cap), .cnt_conf(cnt_conf)
  );

  // Narrow counters to reach saturation (R11).
  mcls_classifier #(.ADDR_W(AW), .NUM_BLOCKS(NB), .CNT_W(SW)) dut_sat (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .res_valid(s_valid), .res_class(s_class), .cnt_refs(s_refs),
    .cnt_hit(s_hit), .cnt_comp(s_comp), .cnt_cap(s_cap), .cnt_conf(s_conf)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  // Reference model state
  bit          m_dv [NB];
  int          m_da [NB];
  int          m_fa [$];
  bit [(1<<AW)-1:0] m_seen;
  int          m_cnt [4];
  int          m_refs;
  logic [1:0]  last_cls;
  string       cur_tag;

  logic [1:0]  exp_q [$];
  string       tag_q [$];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NB; i++) begin m_dv[i] = 0; m_da[i] = 0; end
    m_fa.delete();
    m_seen = '0;
    for (int k = 0; k < 4; k++) m_cnt[k] = 0;
    m_refs = 0;
  endtask

  task automatic send(input int a);
    logic [1:0] c;
    int pos;
    bit dmh;
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = AW'(a);
    dmh = m_dv[a % NB] && (m_da[a % NB] == a);
    pos = -1;
    foreach (m_fa[k]) if (m_fa[k] == a) pos = k;
    if (dmh)            c = 2'b00;
    else if (!m_seen[a]) c = 2'b01;
    else if (pos >= 0)  c = 2'b11;
    else                c = 2'b10;
    m_dv[a % NB] = 1'b1;
    m_da[a % NB] = a;
    if (pos >= 0) m_fa.delete(pos);
    m_fa.push_front(a);
    if (m_fa.size() > NB) void'(m_fa.pop_back());
    m_seen[a] = 1'b1;
    m_cnt[c]++;
    m_refs++;
    last_cls = c;
    exp_q.push_back(c);
    tag_q.push_back(cur_tag);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      req_valid = 1'b0;
    end
  endtask

  // Monitor / scoreboard
  always @(posedge clk) begin
    bit was;
    logic [1:0] e;
    string t;
    was = req_valid && rst_n;
    #1;
    if (rst_n && !finished) begin
      if (res_valid !== was) begin
        chk(1'b0, "R1 res_valid", longint'(res_valid), longint'(was));
      end else if (was) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R1 unexpected result", 1, 0);
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(res_class === e, {t, " R2 class"}, longint'(res_class), longint'(e));
        end
      end
    end
  end

  task automatic check_counters(input string tag);
    int comp_exp;
    comp_exp = $countones(m_seen);
    chk(cnt_refs == CW'(m_refs),    {tag, " R10 refs"}, cnt_refs, m_refs);
    chk(cnt_hit  == CW'(m_cnt[0]),  {tag, " R10 hit"},  cnt_hit,  m_cnt[0]);
    chk(cnt_comp == CW'(comp_exp),  {tag, " R4 comp"},  cnt_comp, comp_exp);
    chk(cnt_cap  == CW'(m_cnt[2]),  {tag, " R10 cap"},  cnt_cap,  m_cnt[2]);
    chk(cnt_conf == CW'(m_cnt[3]),  {tag, " R10 conf"}, cnt_conf, m_cnt[3]);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      finished = 1;
      chk(1'b0, "watchdog", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int a, c, cm, rf;
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_addr = '0;
    cur_tag = "R3";
    model_reset();
    repeat (3) @(negedge clk);
    // R12: reset state
    chk(res_valid == 1'b0, "R12 res_valid in reset", res_valid, 0);
    chk(cnt_refs == '0 && cnt_comp == '0, "R12 counters in reset", cnt_refs, 0);
    rst_n = 1'b1;

    // R9: A=0 B=2 C=4 all in set 0 of a two-block cache
    cur_tag = "R9";
    send(4); send(4); send(2); send(4); send(2); send(4); send(0); send(4); send(2);
    idle(2);
    chk(cnt_comp == 3, "R9 compulsory total", cnt_comp, 3);
    chk(cnt_hit  == 1, "R9 hit total",        cnt_hit,  1);
    chk(cnt_conf == 4, "R9 conflict total",   cnt_conf, 4);
    chk(cnt_cap  == 1, "R9 capacity total",   cnt_cap,  1);
    chk(cnt_refs == 9, "R9 reference total",  cnt_refs, 9);

    // R1: idle cycles change nothing
    rf = int'(cnt_refs);
    idle(4);
    chk(cnt_refs == CW'(rf), "R1 refs stable while idle", cnt_refs, rf);

    // R8: back-to-back repeat of a new address
    cur_tag = "R8";
    send(9); send(9);
    idle(2);
    chk(last_cls == 2'b00, "R8 repeat is hit", last_cls, 0);

    // R5: index = low bit; other set leaves this one intact
    cur_tag = "R5";
    send(1); send(8); send(1);
    idle(2);
    chk(last_cls == 2'b00, "R5 same set tag hit", last_cls, 0);

    // R7: recency refreshed on hit decides the victim
    cur_tag = "R7";
    send(6); send(7); send(6); send(12); send(6);
    idle(2);
    chk(last_cls == 2'b11, "R7 LRU recency on hit", last_cls, 3);

    // R6 / R3: random mix with idle gaps
    cur_tag = "R6";
    for (int i = 0; i < 400; i++) begin
      a = $urandom_range(0, 7);
      if ($urandom_range(0, 9) == 0) a = $urandom_range(0, (1 << AW) - 1);
      send(a);
      if ($urandom_range(0, 4) == 0) idle(1);
    end
    idle(2);
    check_counters("R6");

    // R11: narrow counters saturate
    chk(s_refs == '1, "R11 narrow refs saturated", s_refs, 15);
    cm = $countones(m_seen);
    c = (cm > 15) ? 15 : cm;
    chk(s_comp == SW'(c), "R11 narrow comp", s_comp, c);

    // R12: reset mid-run, then a previously seen address is compulsory again
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(res_valid == 1'b0 && cnt_refs == '0, "R12 cleared by reset", cnt_refs, 0);
    chk(s_refs == '0, "R12 narrow cleared", s_refs, 0);
    model_reset();
    @(negedge clk);
    rst_n = 1'b1;
    cur_tag = "R12";
    send(6);
    idle(2);
    chk(last_cls == 2'b01 && cnt_comp == 1, "R12 first ref after reset compulsory", cnt_comp, 1);
    cur_tag = "R3";
    send(5); send(13); send(21);
    idle(2);
    check_counters("R3");

    idle(2);
    chk(exp_q.size() == 0, "R1 all results seen", exp_q.size(), 0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule